// File: doc/BRIEF.md
# SECDED Word Protection Unit with Scrub Write-Back

This unit sits between a requester and a word-wide memory. Every 64-bit word written through it is stored as a 72-bit codeword: a Hamming code over 71 positions plus one bit of overall parity. Every read is decoded on return. Any single flipped bit is repaired before the data reaches the requester. Any pair of flipped bits is reported as uncorrectable.

When scrubbing is switched on, a repaired word is written back to its address. That write-back happens before the response is offered and before any further request is accepted, so a following access can never see the faulty copy. Two saturating event counters, one for repaired reads and one for uncorrectable reads, are exposed as plain outputs. Each has its own clear pin.

The request and response sides are valid/ready streams. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle. A read response, once raised, stays up with stable contents until `rsp_ready` is seen high. The memory port has no back-pressure: the memory reads with a fixed latency of one cycle, so `mem_rdata` is valid in the cycle after `mem_en` is high with `mem_we` low.

Top module: `ecc_scrub_unit`

## Requirements
- R1: Codeword layout. Bit 0 is the overall parity bit, chosen so that all 72 bits XOR to zero. Bits 1..71 are Hamming positions, with check bits at 1, 2, 4, 8, 16, 32 and 64. Data bits fill the other positions in ascending order, starting with data bit 0. Check bit 2^k makes the XOR of every position with bit k set equal to zero. Data 1 therefore encodes to 72'hF.
- R2: A read of an unaltered codeword returns the written data with both `rsp_corrected` and `rsp_uncorrectable` low.
- R3: A read with exactly one flipped bit anywhere in the 72 bits returns the original data with `rsp_corrected` high and `rsp_uncorrectable` low. This includes a flipped check bit or the parity bit, where the data is returned unchanged.
- R4: A read with exactly two flipped bits sets `rsp_uncorrectable` high and `rsp_corrected` low, and leaves memory untouched.
- R5: With `scrub_en` high, a corrected read writes the repaired codeword to the same address. This happens before the response is raised and before the next request is accepted.
- R6: With `scrub_en` low, a corrected read issues no memory write, and the faulty copy stays in memory.
- R7: `corr_count` and `unc_count` each rise by one per corrected or uncorrectable read, and hold at 2^CNT_W-1.
- R8: A high `corr_clr` or `unc_clr` sets its counter to zero on the next clock edge, taking precedence over an increment in the same cycle.
- R9: `req_ready` is high only while idle, and a write completes in its acceptance cycle with no response. `rsp_valid`, `rsp_data` and the flags hold steady while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Enables write-back of repaired words |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 64 | Read data, corrected where possible |
| rsp_corrected | output | 1 | Response carried a repaired single error |
| rsp_uncorrectable | output | 1 | Response carried an uncorrectable error |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 72 | Codeword to store |
| mem_rdata | input | 72 | Codeword read, one cycle after the strobe |
| corr_clr | input | 1 | Clears the corrected counter |
| unc_clr | input | 1 | Clears the uncorrectable counter |
| corr_count | output | CNT_W | Saturating corrected-event count |
| unc_count | output | CNT_W | Saturating uncorrectable-event count |

## Verification
The bench flips the parity bit, a check bit, the top data position and random pairs of positions. Under these cases, a wrong syndrome mapping or parity polarity would return altered data, flag a double error as single, or report a check-bit error as clean.

It compares memory contents after each read. This catches a missing or mistargeted write-back, a write-back with scrubbing off, and a write-back after a double error.

It also drives the counters past their limit and clears them. A counter that wraps would read low after overflow, and one that ignores its clear would read non-zero.

Randomly stalled responses expose a response that changes while `rsp_ready` is low.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 64;
  localparam int CW_W   = 72;
  localparam int SYN_W  = 7;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_WAIT = 2'd1,
    ST_SCRUB   = 2'd2,
    ST_RESP    = 2'd3
  } ctl_state_t;

  function automatic logic is_pow2(input int v);
    return ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  always_comb begin
    logic [CW_W-1:0] w;
    logic            b;
    int              j;
    w = '0;
    j = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        w[p] = data_i[j];
        j++;
      end
    end
    for (int k = 0; k < SYN_W; k++) begin
      b = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (p[k]) b = b ^ w[p];
      end
      w[1 << k] = b;
    end
    w[0] = ^w[CW_W-1:1];
    cw_o = w;
  end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CW_W-1:0]   fixed_o,
  output logic              single_o,
  output logic              double_o
);
  logic [SYN_W-1:0] syn;
  logic             par;

  always_comb begin
    syn = '0;
    for (int k = 0; k < SYN_W; k++) begin
      for (int p = 1; p < CW_W; p++) begin
        if (p[k]) syn[k] = syn[k] ^ cw_i[p];
      end
    end
    par = ^cw_i;
  end

  always_comb begin
    fixed_o = cw_i;
    for (int p = 0; p < CW_W; p++) begin
      if (par && (syn == SYN_W'(p))) fixed_o[p] = ~cw_i[p];
    end
  end

  always_comb begin
    int j;
    data_o = '0;
    j = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        data_o[j] = fixed_o[p];
        j++;
      end
    end
  end

  assign single_o = par && (int'(syn) < CW_W);
  assign double_o = (!par && (syn != '0)) || (par && (int'(syn) >= CW_W));
endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)               cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX && !clr_i) |=> (cnt_o == CNT_MAX)); // R7
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0)); // R8
endmodule

// File: rtl/ecc_scrub_unit.sv
module ecc_scrub_unit
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_corrected,
  output logic              rsp_uncorrectable,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CW_W-1:0]   mem_wdata,
  input  logic [CW_W-1:0]   mem_rdata,
  input  logic              corr_clr,
  input  logic              unc_clr,
  output logic [CNT_W-1:0]  corr_count,
  output logic [CNT_W-1:0]  unc_count
);
  localparam int N_CNT = 2;

  ctl_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CW_W-1:0]   fix_q;
  logic [CW_W-1:0]   enc_cw;
  logic [CW_W-1:0]   dec_fixed;
  logic [DATA_W-1:0] dec_data;
  logic              dec_single;
  logic              dec_double;
  logic [N_CNT-1:0]  cnt_inc;
  logic [N_CNT-1:0]  cnt_clr;
  logic [CNT_W-1:0]  cnt_val [N_CNT];

  ecc_encoder u_enc (
    .data_i (req_wdata),
    .cw_o   (enc_cw)
  );

  ecc_decoder u_dec (
    .cw_i     (mem_rdata),
    .data_o   (dec_data),
    .fixed_o  (dec_fixed),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = req_addr;
    mem_wdata = enc_cw;
    if (state_q == ST_IDLE && req_valid) begin
      mem_en = 1'b1;
      mem_we = req_write;
    end else if (state_q == ST_SCRUB) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = addr_q;
      mem_wdata = fix_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q           <= ST_IDLE;
      addr_q            <= '0;
      fix_q             <= '0;
      rsp_data          <= '0;
      rsp_corrected     <= 1'b0;
      rsp_uncorrectable <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid && !req_write) begin
            addr_q  <= req_addr;
            state_q <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: begin
          rsp_data          <= dec_data;
          rsp_corrected     <= dec_single;
          rsp_uncorrectable <= dec_double;
          fix_q             <= dec_fixed;
          state_q           <= (dec_single && scrub_en) ? ST_SCRUB : ST_RESP;
        end
        ST_SCRUB: state_q <= ST_RESP;
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnt_inc = {(state_q == ST_RD_WAIT) && dec_double,
                    (state_q == ST_RD_WAIT) && dec_single};
  assign cnt_clr = {unc_clr, corr_clr};

  for (genvar g = 0; g < N_CNT; g++) begin : gen_cnt
    ecc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (cnt_inc[g]),
      .clr_i (cnt_clr[g]),
      .cnt_o (cnt_val[g])
    );
  end

  assign corr_count = cnt_val[0];
  assign unc_count  = cnt_val[1];

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
      $stable(rsp_corrected) && $stable(rsp_uncorrectable))); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_corrected && rsp_uncorrectable)); // R4
  AST_SCRUB_ONLY_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !req_ready) |-> (rsp_corrected && !rsp_valid)); // R5
  AST_SCRUB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !req_ready) |-> (mem_addr == $past(mem_addr, 2))); // R5
endmodule

// File: tb/ecc_scrub_unit_tb_top.sv
`timescale 1ns/1ps
module ecc_scrub_unit_tb_top;
  localparam int AW   = 4;
  localparam int CNTW = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scrub_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_corrected, rsp_uncorrectable;
  logic rsp_ready = 1'b0;
  logic [63:0] rsp_data;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [71:0] mem_wdata, mem_rdata;
  logic corr_clr = 1'b0, unc_clr = 1'b0;
  logic [CNTW-1:0] corr_count, unc_count;

  logic [71:0] ram [16];
  logic inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [71:0] inj_mask = '0;

  int errors = 0, checks = 0, exp_corr = 0, exp_unc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_scrub_unit #(.ADDR_W(AW), .CNT_W(CNTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_corrected(rsp_corrected), .rsp_uncorrectable(rsp_uncorrectable),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .corr_clr(corr_clr), .unc_clr(unc_clr),
    .corr_count(corr_count), .unc_count(unc_count)
  );

  always @(posedge clk) begin
    if (inj_en) ram[inj_addr] <= ram[inj_addr] ^ inj_mask;
    else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
  end

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    chk("R9 ready when idle", 72'(req_ready), 72'd1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = a; inj_mask = m;
    @(posedge clk);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int stall,
                         output logic [63:0] d, output logic c, output logic u);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; c = rsp_corrected; u = rsp_uncorrectable;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R9 response held", {5'd0, rsp_valid, rsp_corrected, rsp_data, rsp_uncorrectable},
          {5'd0, 1'b1, c, d, u});
    end
    chk("R9 not ready while responding", 72'(req_ready), 72'd0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic pulse_clr(input bit which_unc);
    @(negedge clk);
    if (which_unc) unc_clr = 1'b1; else corr_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    unc_clr = 1'b0; corr_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, wd;
    logic c, u;
    logic [71:0] clean, m;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset ready", 72'(req_ready), 72'd1);
    chk("R9 reset no response", 72'(rsp_valid), 72'd0);
    chk("R7 reset counts", {64'd0, corr_count, unc_count}, 72'd0);
    scrub_en = 1'b1;

    // R1 encoding
    do_write(0, 64'd1);
    chk("R1 encode data 1", ram[0], 72'hF);
    do_write(1, 64'h8000_0000_0000_0000);
    chk("R1 encode top bit", ram[1], (72'd1 << 71) | (72'd1 << 64) | 72'h17);

    // R2 clean read
    do_read(1, 0, d, c, u);
    chk("R2 clean data", 72'(d), 72'h8000_0000_0000_0000);
    chk("R2 clean flags", {70'd0, c, u}, 72'd0);

    // R3 data bit flip, R5 scrub
    inject(0, 72'd1 << 3);
    do_read(0, 1, d, c, u);
    chk("R3 single data fix", 72'(d), 72'd1);
    chk("R3 single flags", {70'd0, c, u}, 72'b10);
    chk("R5 scrub repaired memory", ram[0], 72'hF);
    exp_corr++;
    chk("R7 corr count 1", 72'(corr_count), 72'(exp_corr));

    // R3 check bit and parity bit flips
    inject(1, 72'd1 << 4);
    do_read(1, 0, d, c, u);
    chk("R3 check bit data unchanged", 72'(d), 72'h8000_0000_0000_0000);
    chk("R3 check bit flags", {70'd0, c, u}, 72'b10);
    inject(1, 72'd1);
    do_read(1, 2, d, c, u);
    chk("R3 parity bit flags", {70'd0, c, u}, 72'b10);
    chk("R3 parity bit data", 72'(d), 72'h8000_0000_0000_0000);
    exp_corr += 2;

    // R6 scrub disabled
    scrub_en = 1'b0;
    inject(0, 72'd1 << 10);
    do_read(0, 0, d, c, u);
    chk("R6 corrected without scrub", {6'd0, c, u, d}, {6'd0, 2'b10, 64'd1});
    chk("R6 memory left faulty", ram[0], 72'hF ^ (72'd1 << 10));
    scrub_en = 1'b1;
    do_read(0, 0, d, c, u);
    chk("R5 scrub after re-enable", ram[0], 72'hF);
    exp_corr += 2;

    // R4 double error
    clean = ram[1];
    inject(1, (72'd1 << 5) | (72'd1 << 20));
    do_read(1, 1, d, c, u);
    chk("R4 double flags", {70'd0, c, u}, 72'b01);
    chk("R4 no write-back", ram[1], clean ^ ((72'd1 << 5) | (72'd1 << 20)));
    exp_unc++;
    chk("R7 unc count", 72'(unc_count), 72'(exp_unc));
    chk("R7 corr count", 72'(corr_count), 72'(exp_corr));

    // R8 clear
    pulse_clr(1'b0);
    chk("R8 corr cleared", 72'(corr_count), 72'd0);
    chk("R8 unc kept", 72'(unc_count), 72'(exp_unc));
    exp_corr = 0;
    pulse_clr(1'b1);
    chk("R8 unc cleared", 72'(unc_count), 72'd0);
    exp_unc = 0;

    // random mix
    for (int it = 0; it < 60; it++) begin
      int a, nf, p1, p2;
      a  = $urandom % 16;
      wd = {$urandom, $urandom};
      nf = $urandom % 3;
      do_write(a[AW-1:0], wd);
      clean = ram[a];
      p1 = $urandom % 72;
      p2 = (p1 + 1 + ($urandom % 71)) % 72;
      m = '0;
      if (nf >= 1) m[p1] = 1'b1;
      if (nf == 2) m[p2] = 1'b1;
      if (nf != 0) inject(a[AW-1:0], m);
      do_read(a[AW-1:0], $urandom % 3, d, c, u);
      if (nf == 0) begin
        chk("R2 random clean", {6'd0, c, u, d}, {6'd0, 2'b00, wd});
      end else if (nf == 1) begin
        chk("R3 random single", {6'd0, c, u, d}, {6'd0, 2'b10, wd});
        chk("R5 random scrub", ram[a], clean);
        exp_corr = sat(exp_corr + 1);
      end else begin
        chk("R4 random double", {70'd0, c, u}, 72'b01);
        chk("R4 random no write", ram[a], clean ^ m);
        exp_unc = sat(exp_unc + 1);
      end
      chk("R7 random counts", {64'd0, corr_count, unc_count},
          {64'd0, CNTW'(exp_corr), CNTW'(exp_unc)});
    end

    // R7 saturation
    pulse_clr(1'b0);
    do_write(2, 64'hDEAD_BEEF_0123_4567);
    for (int n = 0; n < 18; n++) begin
      inject(2, 72'd1 << (n + 30));
      do_read(2, 0, d, c, u);
    end
    chk("R7 corr saturates", 72'(corr_count), 72'(CMAX));
    chk("R7 saturation data intact", 72'(d), 72'hDEAD_BEEF_0123_4567);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule